// File: doc/BRIEF.md
# Serial Flash Write-Protect Gate

This block decides whether a data-modifying command reaching a serial NOR flash slave may proceed. The serial front end hands it one strobe per decoded command, together with the number of clock edges counted while the device was selected, a 22-bit byte address and, for a status write, the new status byte. The gate holds the write-enable latch, the three-bit protection level and the status-lock bit. It answers every modifying command with a one-cycle accept or reject pulse. The program and erase engines are modelled by a single completion input.

The protected region grows downward from the top block of a 4 MB array, which is made of 64 blocks of 64 KB. A status lock combined with the external write-protect pin freezes the protection bits. A sleep state shuts out every command except the wake command. Status is always visible as one byte.

Top module: `sflash_wprot_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, deep_sleep is 0, and cmd_accept and cmd_reject are both 0.
- R2: Opcodes on cmd_op are: 1 set-write-enable, 2 clear-write-enable, 3 status write, 4 page program, 5 sector erase, 6 block erase, 7 chip erase, 8 sleep, 9 wake. Opcodes 3 to 7 are the modifying commands. Opcode 1 sets the write-enable latch and opcode 2 clears it, one cycle after the strobe.
- R3: A modifying command whose cmd_bits is zero or not a multiple of 8 is rejected.
- R4: A modifying command that arrives with the write-enable latch clear is rejected.
- R5: The protection level L (status bits 4:2) protects no block for L=0 and every block for L=7. For L=1 to 6 it protects blocks 64-2^(L-1) to 63, where the block index is address bits 21:16.
- R6: Page program, sector erase and block erase are rejected when the block index of cmd_addr is protected. Chip erase is rejected whenever L is nonzero.
- R7: While the status-lock bit (status bit 7) is 1 and wp_n is 0, a status write is rejected. An accepted status write loads bit 7 and bits 4:2 from cmd_data.
- R8: An accepted command sets the busy bit. A rejected command leaves the write-enable latch unchanged. A one-cycle op_done pulse while busy clears both busy and the write-enable latch. op_done while idle changes nothing.
- R9: While busy, modifying commands are rejected and opcodes 1, 2 and 8 are ignored.
- R10: Opcode 8 raises deep_sleep. While deep_sleep is 1, every command other than opcode 9 is ignored: no pulse and no status change. Opcode 9 clears deep_sleep.
- R11: The status byte is {lock, 0, 0, L[2:0], write-enable latch, busy}.
- R12: The decision appears on the clock edge that samples cmd_valid, for one cycle. Every modifying command outside deep sleep gets exactly one of cmd_accept or cmd_reject. Any other command gets neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 4 | Command opcode (see R2) |
| cmd_bits | input | 16 | Clock edges counted while selected |
| cmd_addr | input | 22 | Target byte address |
| cmd_data | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Completion pulse from the program/erase engine |
| cmd_accept | output | 1 | Modifying command accepted |
| cmd_reject | output | 1 | Modifying command rejected |
| status | output | 8 | Status byte (see R11) |
| deep_sleep | output | 1 | Deep sleep state |

## Verification
The assertions assume that cmd_valid is a single-cycle strobe and that op_done is a single-cycle pulse. They also assume that cmd_bits and cmd_addr are stable whenever cmd_valid is high, and that wp_n changes only between commands. The bench drives every input on the falling clock edge. It raises each strobe and each completion pulse for exactly one cycle and never asserts op_done during a cycle that carries a command.

// File: rtl/sfwp_pkg.sv
package sfwp_pkg;

   // Command codes delivered by the serial front end
   typedef enum logic [3:0] {
      OP_NONE   = 4'd0,
      OP_WEN    = 4'd1,
      OP_WDIS   = 4'd2,
      OP_WSTAT  = 4'd3,
      OP_PROG   = 4'd4,
      OP_SERASE = 4'd5,
      OP_BERASE = 4'd6,
      OP_CERASE = 4'd7,
      OP_SLEEP  = 4'd8,
      OP_WAKE   = 4'd9
   } op_e;

   // Field positions inside the status byte
   localparam int LOCK_BIT = 7;
   localparam int LVL_LSB  = 2;
   localparam int WEL_BIT  = 1;
   localparam int BUSY_BIT = 0;

   // Per-cycle decision produced by the judge
   typedef struct packed {
      logic acc;
      logic rej;
      logic wel_set;
      logic wel_clr;
      logic sleep;
      logic wake;
   } verdict_t;

   function automatic logic is_modify(op_e op);
      return (op == OP_WSTAT) || (op == OP_PROG) || (op == OP_SERASE) ||
             (op == OP_BERASE) || (op == OP_CERASE);
   endfunction

   function automatic logic is_ranged(op_e op);
      return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_BERASE);
   endfunction

endpackage

// File: rtl/sfwp_region.sv
// Decodes the protection level into a hit flag for one block index.
module sfwp_region #(
   parameter int BLK_IDX_W = 6,
   parameter int LVL_W     = 3,
   parameter int IMPL      = 0
) (
   input  logic [LVL_W-1:0]     lvl,
   input  logic [BLK_IDX_W-1:0] blk,
   output logic                 hit,
   output logic                 any_on
);
   localparam int NUM_LVL = 1 << LVL_W;
   localparam int NUM_BLK = 1 << BLK_IDX_W;

   assign any_on = |lvl;

   generate
      if (IMPL == 0) begin : g_arith
         // Span of protected blocks, then a single magnitude compare
         logic [BLK_IDX_W:0] span;
         logic [BLK_IDX_W:0] floor_blk;
         always_comb begin
            if (lvl == '0)
               span = '0;
            else if (&lvl)
               span = (BLK_IDX_W+1)'(NUM_BLK);
            else
               span = (BLK_IDX_W+1)'(1) << (lvl - 1'b1);
            floor_blk = (BLK_IDX_W+1)'(NUM_BLK) - span;
            hit       = ({1'b0, blk} >= floor_blk);
         end
      end else begin : g_mask
         // Level k protects the blocks whose upper index bits are all ones
         logic [NUM_LVL-1:0] lvl_hit;
         assign lvl_hit[0]         = 1'b0;
         assign lvl_hit[NUM_LVL-1] = 1'b1;
         for (genvar k = 1; k < NUM_LVL - 1; k++) begin : g_lvl
            assign lvl_hit[k] = &blk[BLK_IDX_W-1:k-1];
         end
         assign hit = lvl_hit[lvl];
      end
   endgenerate

endmodule

// File: rtl/sfwp_judge.sv
// Combinational acceptance decision for the command on the bus this cycle.
module sfwp_judge
   import sfwp_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int GRAN_W = 3
) (
   input  logic             cmd_valid,
   input  op_e              op,
   input  logic [CNT_W-1:0] bits,
   input  logic             wel,
   input  logic             busy,
   input  logic             lock,
   input  logic             wp_n,
   input  logic             asleep,
   input  logic             blk_hit,
   input  logic             any_on,
   output verdict_t         v
);
   logic bits_ok;
   logic hw_frozen;

   assign bits_ok   = (bits[GRAN_W-1:0] == '0) && (bits != '0);
   assign hw_frozen = lock && !wp_n;

   always_comb begin
      v = '0;
      if (cmd_valid) begin
         if (asleep) begin
            if (op == OP_WAKE) v.wake = 1'b1;
         end else if (is_modify(op)) begin
            if (busy || !bits_ok || !wel)
               v.rej = 1'b1;
            else if ((op == OP_WSTAT) && hw_frozen)
               v.rej = 1'b1;
            else if (is_ranged(op) && blk_hit)
               v.rej = 1'b1;
            else if ((op == OP_CERASE) && any_on)
               v.rej = 1'b1;
            else
               v.acc = 1'b1;
         end else if (!busy) begin
            case (op)
               OP_WEN:   v.wel_set = 1'b1;
               OP_WDIS:  v.wel_clr = 1'b1;
               OP_SLEEP: v.sleep   = 1'b1;
               default:  ;
            endcase
         end
      end
   end

endmodule

// File: rtl/sfwp_regs.sv
// State held by the gate: latch, busy, lock, level, sleep and the decision pulses.
module sfwp_regs
   import sfwp_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  verdict_t         v,
   input  logic             is_wstat,
   input  logic             new_lock,
   input  logic [LVL_W-1:0] new_lvl,
   input  logic             op_done,
   output logic             wel,
   output logic             busy,
   output logic             lock,
   output logic [LVL_W-1:0] lvl,
   output logic             asleep,
   output logic             acc_q,
   output logic             rej_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel    <= 1'b0;
         busy   <= 1'b0;
         lock   <= 1'b0;
         lvl    <= '0;
         asleep <= 1'b0;
         acc_q  <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         acc_q <= v.acc;
         rej_q <= v.rej;
         if (v.wel_set) wel <= 1'b1;
         if (v.wel_clr) wel <= 1'b0;
         if (v.acc) begin
            busy <= 1'b1;
            if (is_wstat) begin
               lock <= new_lock;
               lvl  <= new_lvl;
            end
         end
         if (op_done && busy) begin
            busy <= 1'b0;
            wel  <= 1'b0;
         end
         if (v.sleep) asleep <= 1'b1;
         if (v.wake)  asleep <= 1'b0;
      end
   end

endmodule

// File: rtl/sflash_wprot_ctrl.sv
// Write-protection gate for a serial NOR flash slave.
module sflash_wprot_ctrl
   import sfwp_pkg::*;
#(
   parameter int ADDR_W      = 22,
   parameter int BLOCK_AW    = 16,
   parameter int SECTOR_AW   = 12,
   parameter int LVL_W       = 3,
   parameter int CNT_W       = 16,
   parameter int GRAN_W      = 3,
   parameter int REGION_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [CNT_W-1:0]  cmd_bits,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic              wp_n,
   input  logic              op_done,
   output logic              cmd_accept,
   output logic              cmd_reject,
   output logic [7:0]        status,
   output logic              deep_sleep
);
   localparam int BLK_IDX_W = ADDR_W - BLOCK_AW;
   localparam int PAD_W     = 5 - LVL_W;

   // Elaboration-time parameter checks
   generate
      if (BLOCK_AW >= ADDR_W) begin : g_bad_blk
         $error("block size must be smaller than the array");
      end
      if (SECTOR_AW > BLOCK_AW) begin : g_bad_sec
         $error("a sector must fit inside one block");
      end
      if (LVL_W < 1 || LVL_W > 3) begin : g_bad_lvl
         $error("level field must be 1 to 3 bits to fit the status byte");
      end
      if ((1 << LVL_W) - 2 > BLK_IDX_W) begin : g_bad_span
         $error("protection levels exceed the block count");
      end
      if (GRAN_W < 1 || GRAN_W >= CNT_W) begin : g_bad_gran
         $error("granule width must be below the counter width");
      end
      if (REGION_IMPL != 0 && REGION_IMPL != 1) begin : g_bad_impl
         $error("REGION_IMPL must be 0 or 1");
      end
   endgenerate

   op_e                  op;
   verdict_t             v;
   logic                 wel, busy, lock, asleep;
   logic [LVL_W-1:0]     lvl;
   logic                 blk_hit, any_on;
   logic [BLK_IDX_W-1:0] blk;

   assign op  = op_e'(cmd_op);
   // A sector is wholly inside one block, so the block index covers every target
   assign blk = cmd_addr[ADDR_W-1:BLOCK_AW];

   sfwp_region #(
      .BLK_IDX_W (BLK_IDX_W),
      .LVL_W     (LVL_W),
      .IMPL      (REGION_IMPL)
   ) u_region (
      .lvl    (lvl),
      .blk    (blk),
      .hit    (blk_hit),
      .any_on (any_on)
   );

   sfwp_judge #(
      .CNT_W  (CNT_W),
      .GRAN_W (GRAN_W)
   ) u_judge (
      .cmd_valid (cmd_valid),
      .op        (op),
      .bits      (cmd_bits),
      .wel       (wel),
      .busy      (busy),
      .lock      (lock),
      .wp_n      (wp_n),
      .asleep    (asleep),
      .blk_hit   (blk_hit),
      .any_on    (any_on),
      .v         (v)
   );

   sfwp_regs #(
      .LVL_W (LVL_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .v        (v),
      .is_wstat (op == OP_WSTAT),
      .new_lock (cmd_data[LOCK_BIT]),
      .new_lvl  (cmd_data[LVL_LSB +: LVL_W]),
      .op_done  (op_done),
      .wel      (wel),
      .busy     (busy),
      .lock     (lock),
      .lvl      (lvl),
      .asleep   (asleep),
      .acc_q    (cmd_accept),
      .rej_q    (cmd_reject)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign status = {lock, {PAD_W{1'b0}}, lvl, wel, busy};
      end else begin : g_nopad
         assign status = {lock, lvl, wel, busy};
      end
   endgenerate

   assign deep_sleep = asleep;

endmodule

// File: rtl/sfwp_checker.sv
// Temporal checks on the gate, bound to the top module.
module sfwp_checker #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [3:0]        cmd_op,
   input logic [CNT_W-1:0]  cmd_bits,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              wp_n,
   input logic              op_done,
   input logic              cmd_accept,
   input logic              cmd_reject,
   input logic [7:0]        status,
   input logic              deep_sleep
);
   logic modify;
   assign modify = (cmd_op >= 4'd3) && (cmd_op <= 4'd7);

   // R12: never both answers at once
   a_r12_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_accept && cmd_reject));

   // R12: non-modifying commands get no answer
   a_r12_quiet_other: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !modify) |=> (!cmd_accept && !cmd_reject));

   // R3: bad clock count never accepted
   a_r3_bitcount: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && modify && (cmd_bits[2:0] != 3'd0)) |=> !cmd_accept);

   // R4: latch clear never accepted
   a_r4_need_wel: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && modify && !status[1]) |=> !cmd_accept);

   // R7: hardware lock blocks status writes
   a_r7_hw_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 4'd3 && status[7] && !wp_n) |=>
         (!cmd_accept && $stable(status[7:2])));

   // R8: rejection keeps the latch
   a_r8_rej_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reject |-> (status[1] == $past(status[1])));

   // R8: completion clears busy and latch
   a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && op_done) |=> (status[1:0] == 2'b00));

   // R9: busy rejects modifying commands
   a_r9_busy_rej: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && modify && status[0] && !deep_sleep) |=> cmd_reject);

   // R10: sleep ignores all but wake
   a_r10_sleep_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (deep_sleep && cmd_valid && cmd_op != 4'd9 && !op_done) |=>
         (!cmd_accept && !cmd_reject && deep_sleep && $stable(status)));

   // R11: reserved status bits stay zero
   a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      status[6:5] == 2'b00);

endmodule

bind sflash_wprot_ctrl sfwp_checker #(
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .cmd_bits   (cmd_bits),
   .cmd_addr   (cmd_addr),
   .wp_n       (wp_n),
   .op_done    (op_done),
   .cmd_accept (cmd_accept),
   .cmd_reject (cmd_reject),
   .status     (status),
   .deep_sleep (deep_sleep)
);

// File: tb/sflash_wprot_ctrl_test.sv
`timescale 1ns/1ps
module sflash_wprot_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic [15:0] cmd_bits = '0;
   logic [21:0] cmd_addr = '0;
   logic [7:0]  cmd_data = '0;
   logic        wp_n = 1'b1;
   logic        op_done = 1'b0;
   logic        cmd_accept, cmd_reject, deep_sleep;
   logic [7:0]  status;

   int checks = 0;
   int errors = 0;
   logic got_acc, got_rej;

   always #4 clk = ~clk;

   sflash_wprot_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_bits(cmd_bits), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .wp_n(wp_n), .op_done(op_done), .cmd_accept(cmd_accept),
      .cmd_reject(cmd_reject), .status(status), .deep_sleep(deep_sleep)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] op, input int nbits,
                        input logic [21:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_bits = nbits[15:0];
      cmd_addr = a; cmd_data = d;
      @(negedge clk);
      got_acc = cmd_accept; got_rej = cmd_reject;
      cmd_valid = 1'b0;
   endtask

   task automatic finish_op();
      @(negedge clk); op_done = 1'b1;
      @(negedge clk); op_done = 1'b0;
   endtask

   // answer encoded as 2 = accept, 1 = reject, 0 = none
   function automatic int ans();
      return {30'd0, got_acc, got_rej};
   endfunction

   function automatic int lowest_prot(input int lvl);
      if (lvl == 0) return 64;
      if (lvl == 7) return 0;
      return 64 - (1 << (lvl - 1));
   endfunction

   task automatic t_reset();
      check("R1 status", status, 8'h00);
      check("R1 deep_sleep", deep_sleep, 0);
      check("R1 pulses", {cmd_accept, cmd_reject}, 0);
   endtask

   task automatic t_latch();
      issue(4'd1, 8, 0, 0);
      check("R2 set latch", status, 8'h02);
      check("R12 no answer for opcode 1", ans(), 0);
      issue(4'd2, 8, 0, 0);
      check("R2 clear latch", status, 8'h00);
   endtask

   task automatic t_no_latch();
      issue(4'd4, 32, 22'h000100, 0);
      check("R4 reject without latch", ans(), 1);
      check("R4 status", status, 8'h00);
   endtask

   task automatic t_bitcount();
      issue(4'd1, 8, 0, 0);
      issue(4'd4, 33, 22'h000200, 0);
      check("R3 odd count rejected", ans(), 1);
      check("R8 latch kept after reject", status, 8'h02);
      issue(4'd4, 0, 22'h000200, 0);
      check("R3 zero count rejected", ans(), 1);
      issue(4'd4, 40, 22'h000200, 0);
      check("R8 accepted", ans(), 2);
      check("R8 busy set", status, 8'h03);
      finish_op();
      check("R8 done clears", status, 8'h00);
      finish_op();
      check("R8 idle done no effect", status, 8'h00);
   endtask

   task automatic t_busy();
      issue(4'd1, 8, 0, 0);
      issue(4'd5, 32, 22'h001000, 0);
      check("R9 sector erase accepted", ans(), 2);
      issue(4'd2, 8, 0, 0);
      check("R9 opcode 2 ignored while busy", status, 8'h03);
      issue(4'd6, 32, 22'h010000, 0);
      check("R9 reject while busy", ans(), 1);
      issue(4'd8, 8, 0, 0);
      check("R9 sleep ignored while busy", deep_sleep, 0);
      finish_op();
      issue(4'd1, 8, 0, 0);
      check("R9 latch works after busy", status, 8'h02);
      issue(4'd2, 8, 0, 0);
   endtask

   task automatic set_level(input int lvl, input logic lk);
      issue(4'd1, 8, 0, 0);
      issue(4'd3, 16, 0, {lk, 2'b00, lvl[2:0], 2'b00});
      check("R7 status write accepted", ans(), 2);
      finish_op();
      check("R11 level field", status, {lk, 2'b00, lvl[2:0], 2'b00});
   endtask

   task automatic t_region();
      for (int lvl = 0; lvl < 8; lvl++) begin
         int lo = lowest_prot(lvl);
         int blks[4] = '{0, lo - 1, lo, 63};
         set_level(lvl, 1'b0);
         for (int i = 0; i < 4; i++) begin
            int b = blks[i];
            logic [3:0] op;
            if (b < 0 || b > 63) continue;
            op = (i % 3 == 0) ? 4'd4 : ((i % 3 == 1) ? 4'd5 : 4'd6);
            issue(4'd1, 8, 0, 0);
            issue(op, 32, {b[5:0], 16'h0A40}, 0);
            if (b < lo) begin
               check("R5 R6 unprotected block accepted", ans(), 2);
               finish_op();
            end else begin
               check("R5 R6 protected block rejected", ans(), 1);
               issue(4'd2, 8, 0, 0);
            end
         end
      end
      issue(4'd1, 8, 0, 0);
      issue(4'd7, 8, 0, 0);
      check("R6 chip erase rejected at nonzero level", ans(), 1);
      issue(4'd2, 8, 0, 0);
      set_level(0, 1'b0);
      issue(4'd1, 8, 0, 0);
      issue(4'd7, 8, 0, 0);
      check("R6 chip erase accepted at level 0", ans(), 2);
      finish_op();
   endtask

   task automatic t_hwlock();
      set_level(1, 1'b1);
      check("R7 lock loaded", status, 8'h84);
      @(negedge clk) wp_n = 1'b0;
      issue(4'd1, 8, 0, 0);
      issue(4'd3, 16, 0, 8'h00);
      check("R7 locked write rejected", ans(), 1);
      check("R7 fields frozen", status, 8'h86);
      @(negedge clk) wp_n = 1'b1;
      issue(4'd3, 16, 0, 8'h00);
      check("R7 unlocked write accepted", ans(), 2);
      finish_op();
      check("R7 fields cleared", status, 8'h00);
   endtask

   task automatic t_sleep();
      issue(4'd8, 8, 0, 0);
      check("R10 enter sleep", deep_sleep, 1);
      issue(4'd1, 8, 0, 0);
      check("R10 opcode 1 ignored", status, 8'h00);
      issue(4'd4, 32, 0, 0);
      check("R10 no answer in sleep", ans(), 0);
      issue(4'd9, 8, 0, 0);
      check("R10 wake", deep_sleep, 0);
      issue(4'd1, 8, 0, 0);
      check("R10 latch after wake", status, 8'h02);
      issue(4'd2, 8, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_no_latch();
      t_bitcount();
      t_busy();
      t_region();
      t_hwlock();
      t_sleep();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule